// File: doc/BRIEF.md
# Local Interrupt Priority Acceptance Unit

This unit sits beside a processor core and decides when an incoming interrupt may interrupt it. Each request carries an 8-bit vector. The unit keeps one bit per vector for requests that are waiting and one bit per vector for interrupts the core has taken but not yet finished. The core is signalled only when the best waiting request belongs to a priority class above two limits: the software-set task priority and every class already being serviced. The core's own interrupt-enable must also be set.

The priority class of a vector is its upper nibble. The lower nibble only orders vectors inside one class, so raising the task priority masks whole groups of 16 vectors at a time. The core takes an interrupt by pulsing an acknowledge input. The offered vector is on an output port, and that vector moves from waiting to in service. The core finishes a handler with an end-of-interrupt pulse, which retires the highest in-service vector. Software writes the task priority, and reads it back, through a small address/data port.

Top module: `prio_accept_unit`

## Requirements
- R1: The priority class of a vector is bits [7:4]. The vector offered on `ackVector` is the highest-numbered waiting vector, so inside the winning class the higher low nibble is served first.
- R2: `intOut` is asserted only when the offered vector's class is strictly greater than bits [7:4] of the task-priority register. That register resets to 0x00.
- R3: Any task-priority value inside a class masks the whole class. For example, 0x2B blocks 0x2F, while 0x30 can still be delivered.
- R4: `intOut` stays low while a vector of the same or a higher class is in service. A waiting vector of a strictly higher class is delivered while a lower class is in service.
- R5: `intOut` is low whenever `coreIntEn` is low.
- R6: A request whose vector is below 0x20 is dropped and never becomes a waiting request.
- R7: An `eoiIn` pulse clears the highest-numbered in-service vector, and only that vector. A waiting request that was blocked only by the retired vector's class becomes deliverable.
- R8: An `ackIn` pulse while `intOut` is high takes the vector shown on `ackVector`. On the following clock edge that vector stops waiting and becomes in service. An `ackIn` pulse while `intOut` is low changes nothing.
- R9: A request for a vector that is already waiting merges with it. One acknowledge and one end-of-interrupt then leave nothing to deliver.
- R10: After reset `intOut` is low. A write with `busAddr` = 0 loads the task priority, and a read at address 0 returns it on `busRdData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, one vector per cycle |
| reqVector | input | 8 | Vector of the request |
| coreIntEn | input | 1 | Core interrupt enable |
| intOut | output | 1 | Interrupt signal to the core |
| ackIn | input | 1 | Core acknowledge pulse |
| ackVector | output | 8 | Vector offered to the core |
| eoiIn | input | 1 | End-of-interrupt pulse |
| busAddr | input | 2 | Register address |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 8 | Register write data |
| busRdData | output | 8 | Register read data |

## Verification
The bench builds the unit with its default parameters: an 8-bit vector, a 4-bit class field and a reserved limit of 32. This gives the full 256-entry maps and puts the exact edges within reach. These are the class edge between 0x2F and 0x30 under a task priority of 0x2B, and the reserved edge at 0x1F against 0x20. Directed scenarios then cover three cases. One nests a higher class over a lower one. One retires only the top in-service vector. One holds a duplicate request while delivery is disabled.

// File: rtl/prio_accept_pkg.sv
package prio_accept_pkg;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic reqFire;   // latch a valid, non-reserved request
    logic ackFire;   // move the offered vector to in-service
    logic eoiFire;   // retire the top in-service vector
    logic tprWrite;  // load the task-priority register
  } strobe_t;

endpackage

// File: rtl/prio_accept_enc.sv
module prio_accept_enc #(
  parameter int N = 256,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     mapIn,
  output logic             anyOut,
  output logic [IDX_W-1:0] idxOut
);

  // The highest set bit wins.
  always_comb begin
    anyOut = 1'b0;
    idxOut = '0;
    for (int i = 0; i < N; i++) begin
      if (mapIn[i]) begin
        anyOut = 1'b1;
        idxOut = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/prio_accept_dp.sv
module prio_accept_dp
  import prio_accept_pkg::*;
#(
  parameter int VEC_W     = 8,
  parameter int RSV_LIMIT = 32,
  localparam int NUM_VEC  = 1 << VEC_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [VEC_W-1:0] reqVec,
  input  logic [VEC_W-1:0] tprWrData,
  output logic             pendAny,
  output logic [VEC_W-1:0] pendVec,
  output logic             isrAny,
  output logic [VEC_W-1:0] isrVec,
  output logic [VEC_W-1:0] tprVal
);

  logic [NUM_VEC-1:0] pendMap;
  logic [NUM_VEC-1:0] isrMap;

  // Waiting requests. A request in the same cycle overrides the clear from an acknowledge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendMap <= '0;
    end else begin
      if (stb.ackFire) pendMap[pendVec] <= 1'b0;
      if (stb.reqFire) pendMap[reqVec]  <= 1'b1;
    end
  end

  // In-service vectors.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isrMap <= '0;
    end else begin
      if (stb.eoiFire) isrMap[isrVec]  <= 1'b0;
      if (stb.ackFire) isrMap[pendVec] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tprVal <= '0;
    else if (stb.tprWrite) tprVal <= tprWrData;
  end

  // One encoder per map.
  for (genvar g = 0; g < 2; g++) begin : gEnc
    if (g == 0) begin : gPend
      prio_accept_enc #(.N(NUM_VEC)) uEnc (
        .mapIn(pendMap), .anyOut(pendAny), .idxOut(pendVec));
    end else begin : gIsr
      prio_accept_enc #(.N(NUM_VEC)) uEnc (
        .mapIn(isrMap), .anyOut(isrAny), .idxOut(isrVec));
    end
  end

  AST_RSV_NEVER_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    pendMap[RSV_LIMIT-1:0] == '0); // R6

  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rstN)
    stb.ackFire |=> isrMap[$past(pendVec)]); // R8

  AST_EOI_CLEARS_TOP: assert property (@(posedge clk) disable iff (!rstN)
    stb.eoiFire && !stb.ackFire |=> !isrMap[$past(isrVec)]); // R7

endmodule

// File: rtl/prio_accept_ctrl.sv
module prio_accept_ctrl
  import prio_accept_pkg::*;
#(
  parameter int VEC_W     = 8,
  parameter int CLASS_W   = 4,
  parameter int RSV_LIMIT = 32,
  parameter int ADDR_W    = 2,
  parameter int TPR_ADDR  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VEC_W-1:0]  reqVec,
  input  logic              ackIn,
  input  logic              eoiIn,
  input  logic              coreIntEn,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              pendAny,
  input  logic [VEC_W-1:0]  pendVec,
  input  logic              isrAny,
  input  logic [VEC_W-1:0]  isrVec,
  input  logic [VEC_W-1:0]  tprVal,
  output strobe_t           stb,
  output logic              intOut
);

  localparam int CLS_LO = VEC_W - CLASS_W;

  logic [CLASS_W-1:0] pendCls, isrCls, tprCls;
  logic               aboveTpr, aboveIsr, eligible;

  assign pendCls  = pendVec[VEC_W-1:CLS_LO];
  assign isrCls   = isrVec[VEC_W-1:CLS_LO];
  assign tprCls   = tprVal[VEC_W-1:CLS_LO];
  assign aboveTpr = pendCls > tprCls;
  assign aboveIsr = !isrAny || (pendCls > isrCls);
  assign eligible = pendAny && aboveTpr && aboveIsr && coreIntEn;
  assign intOut   = eligible;

  always_comb begin
    stb          = '0;
    stb.reqFire  = reqValid && (int'(reqVec) >= RSV_LIMIT);
    stb.ackFire  = ackIn && eligible;
    stb.eoiFire  = eoiIn && isrAny;
    stb.tprWrite = busWrEn && (int'(busAddr) == TPR_ADDR);
  end

  AST_INT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> coreIntEn); // R5

  AST_INT_ABOVE_TPR: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> pendVec[VEC_W-1:CLS_LO] > tprVal[VEC_W-1:CLS_LO]); // R2

  AST_INT_ABOVE_ISR: assert property (@(posedge clk) disable iff (!rstN)
    intOut && isrAny |-> pendVec[VEC_W-1:CLS_LO] > isrVec[VEC_W-1:CLS_LO]); // R4

  AST_ACK_ONLY_ON_INT: assert property (@(posedge clk) disable iff (!rstN)
    stb.ackFire |-> intOut && pendAny); // R8

endmodule

// File: rtl/prio_accept_unit.sv
module prio_accept_unit
  import prio_accept_pkg::*;
#(
  parameter int VEC_W     = 8,
  parameter int CLASS_W   = 4,
  parameter int RSV_LIMIT = 32,
  parameter int ADDR_W    = 2,
  parameter int TPR_ADDR  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VEC_W-1:0]  reqVector,
  input  logic              coreIntEn,
  output logic              intOut,
  input  logic              ackIn,
  output logic [VEC_W-1:0]  ackVector,
  input  logic              eoiIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [VEC_W-1:0]  busWrData,
  output logic [VEC_W-1:0]  busRdData
);

  strobe_t          stb;
  logic             pendAny, isrAny;
  logic [VEC_W-1:0] pendVec, isrVec, tprVal;

  prio_accept_ctrl #(
    .VEC_W(VEC_W), .CLASS_W(CLASS_W), .RSV_LIMIT(RSV_LIMIT),
    .ADDR_W(ADDR_W), .TPR_ADDR(TPR_ADDR)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVec(reqVector),
    .ackIn(ackIn), .eoiIn(eoiIn), .coreIntEn(coreIntEn),
    .busWrEn(busWrEn), .busAddr(busAddr),
    .pendAny(pendAny), .pendVec(pendVec), .isrAny(isrAny), .isrVec(isrVec),
    .tprVal(tprVal), .stb(stb), .intOut(intOut)
  );

  prio_accept_dp #(.VEC_W(VEC_W), .RSV_LIMIT(RSV_LIMIT)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqVec(reqVector),
    .tprWrData(busWrData), .pendAny(pendAny), .pendVec(pendVec),
    .isrAny(isrAny), .isrVec(isrVec), .tprVal(tprVal)
  );

  assign ackVector = pendVec;
  assign busRdData = (int'(busAddr) == TPR_ADDR) ? tprVal : '0;

  AST_TPR_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && int'(busAddr) == TPR_ADDR |=> busRdData == $past(busWrData) || int'(busAddr) != TPR_ADDR); // R10

endmodule

// File: tb/prio_accept_unit_bench.sv
module prio_accept_unit_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [7:0] reqVector = '0;
  logic       coreIntEn = 1'b1;
  logic       intOut;
  logic       ackIn = 1'b0;
  logic [7:0] ackVector;
  logic       eoiIn = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk; // 50 MHz

  prio_accept_unit u_prio_accept_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVector(reqVector),
    .coreIntEn(coreIntEn), .intOut(intOut), .ackIn(ackIn), .ackVector(ackVector),
    .eoiIn(eoiIn), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // Inputs change at a falling edge; the next rising edge consumes them.
  task automatic request(logic [7:0] v);
    @(negedge clk); reqValid = 1'b1; reqVector = v;
    @(negedge clk); reqValid = 1'b0;
  endtask
  task automatic ack();
    @(negedge clk); ackIn = 1'b1;
    @(negedge clk); ackIn = 1'b0;
  endtask
  task automatic eoi();
    @(negedge clk); eoiIn = 1'b1;
    @(negedge clk); eoiIn = 1'b0;
  endtask
  task automatic writeTpr(logic [7:0] v);
    @(negedge clk); busWrEn = 1'b1; busAddr = 2'd0; busWrData = v;
    @(negedge clk); busWrEn = 1'b0;
  endtask

  task automatic testReset();
    check("R10 intOut after reset", {7'd0, intOut}, 8'h00);
    busAddr = 2'd0;
    check("R10 tpr after reset", busRdData, 8'h00);
    writeTpr(8'h5C);
    check("R10 tpr readback", busRdData, 8'h5C);
    writeTpr(8'h00);
  endtask

  task automatic testBasic();
    request(8'h45);
    check("R1 single offer int", {7'd0, intOut}, 8'h01);
    check("R1 single offer vector", ackVector, 8'h45);
    ack();
    check("R8 int drops after ack", {7'd0, intOut}, 8'h00);
    eoi();
    check("R7 nothing left", {7'd0, intOut}, 8'h00);
  endtask

  task automatic testOrder();
    request(8'h51); request(8'h5A); request(8'h33);
    check("R1 highest vector offered", ackVector, 8'h5A);
    ack();
    check("R4 same class blocked", {7'd0, intOut}, 8'h00);
    eoi();
    check("R7 same class released", {7'd0, intOut}, 8'h01);
    check("R1 next in class", ackVector, 8'h51);
    ack(); eoi();
    check("R1 lower class last", ackVector, 8'h33);
    ack();
    request(8'h60);
    check("R4 higher class nests", {7'd0, intOut}, 8'h01);
    check("R4 nested vector", ackVector, 8'h60);
    ack();
    request(8'h40);
    check("R4 blocked by 0x60", {7'd0, intOut}, 8'h00);
    eoi();
    check("R7 top retired, 0x40 above 0x33", {7'd0, intOut}, 8'h01);
    check("R7 offered 0x40", ackVector, 8'h40);
    ack(); eoi(); eoi();
    check("R7 all retired", {7'd0, intOut}, 8'h00);
  endtask

  task automatic testTpr();
    writeTpr(8'h2B);
    request(8'h2F);
    check("R3 0x2F masked by 0x2B", {7'd0, intOut}, 8'h00);
    request(8'h30);
    check("R2 0x30 above tpr", {7'd0, intOut}, 8'h01);
    check("R2 0x30 offered", ackVector, 8'h30);
    ack(); eoi();
    check("R3 still masked", {7'd0, intOut}, 8'h00);
    writeTpr(8'h00);
    check("R2 released by tpr 0", ackVector, 8'h2F);
    check("R2 int after tpr 0", {7'd0, intOut}, 8'h01);
    ack(); eoi();
  endtask

  task automatic testEnable();
    @(negedge clk); coreIntEn = 1'b0;
    request(8'h70);
    check("R5 no int when disabled", {7'd0, intOut}, 8'h00);
    ack();
    @(negedge clk); coreIntEn = 1'b1;
    @(negedge clk);
    check("R8 ack while low ignored", {7'd0, intOut}, 8'h01);
    check("R8 vector kept", ackVector, 8'h70);
    ack(); eoi();
  endtask

  task automatic testReserved();
    request(8'h1F); request(8'h00);
    check("R6 reserved dropped", {7'd0, intOut}, 8'h00);
    request(8'h20);
    check("R6 0x20 accepted", ackVector, 8'h20);
    ack(); eoi();
  endtask

  task automatic testMerge();
    @(negedge clk); coreIntEn = 1'b0;
    request(8'h88); request(8'h88);
    @(negedge clk); coreIntEn = 1'b1;
    @(negedge clk);
    check("R9 merged offer", ackVector, 8'h88);
    ack(); eoi();
    check("R9 no second delivery", {7'd0, intOut}, 8'h00);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testOrder();
    testTpr();
    testEnable();
    testReserved();
    testMerge();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule